// File: doc/BRIEF.md
# Bad-Block Scan Engine

The block runs by itself after reset and surveys every erase block of an attached NAND device. It asks a lower-level command sequencer for single-byte page reads through a request/acknowledge handshake. For each block it reads the first spare byte, at column 2048 just past the 2048-byte data area, of page 0 and then of page 1. If either byte is anything other than the erased value FFh, the block is recorded as bad in a one-bit-per-block table.

The engine only reads. Its request interface can express a page read and nothing else, so the factory marks it inspects are never erased or rewritten. When the last block has been judged, it raises a done flag and goes quiet. Software can read the table and the running count of bad blocks at any time, including while the scan is still in progress.

Top module: `bad_block_scan`

## Requirements
- R1: Out of reset, `req_o` is high for block 0 page 0, while `done_o`, `err_o` and `bad_cnt_o` are all 0 and every table bit reads 0.
- R2: Every request carries column address 2048 and row address `(block << 6) | page`, where page is 0 or 1.
- R3: Each block is read at page 0 first. The page 1 read is issued only if page 0 returned FFh with no error. A marked page 0 moves the scan straight to the next block.
- R4: A block is recorded bad (table bit = 1) exactly when its page 0 or page 1 spare byte is any value other than FFh, including a value with a single zero bit, or when the sequencer reports an error for that read.
- R5: `bad_cnt_o` equals the number of table bits set, rises by at most one per cycle, and is wide enough to count every block without saturating.
- R6: A read acknowledged with `err_i` high marks that block bad and sets `err_o`. `err_o` then stays high until reset.
- R7: Blocks are visited in ascending order, each exactly once, over all 2048 blocks. After the last block, `done_o` goes high and stays high, and `req_o` stays low.
- R8: While `req_o` is high and unacknowledged, `req_o` and `row_o` hold steady. The table read port (`tbl_idx_i` to `tbl_bad_o`, combinational) shows final results for blocks already judged and 0 for blocks not yet reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; starts a new scan on release |
| req_o | output | 1 | Page-read request to the sequencer, held until acknowledged |
| row_o | output | 17 | Row address (block and page) of the request |
| col_o | output | 12 | Column address of the request (always 2048) |
| ack_i | input | 1 | One-cycle acknowledge carrying the read result |
| rdata_i | input | 8 | Byte returned with `ack_i` |
| err_i | input | 1 | Busy or timeout error flagged with `ack_i` |
| done_o | output | 1 | Scan complete |
| err_o | output | 1 | Sticky: at least one sequencer error was seen |
| bad_cnt_o | output | 12 | Number of blocks recorded bad |
| tbl_idx_i | input | 11 | Block index for the table read port |
| tbl_bad_o | output | 1 | Table bit for `tbl_idx_i` (1 = bad) |

## Verification
The scan is driven three times by a sequencer model. The first run has an all-erased device, which separates the two-reads-per-block path from any spurious marking. The second run has a mixed device where marks appear on page 0 only, on page 1 only, as 00h, as single-bit-off 7Fh and FEh values, and as sequencer errors. That run shows whether each mark source is recognised, whether page 1 is skipped after a page 0 mark, and whether the table can be read mid-scan without leaking future results. The third run has every block marked at page 0, which pushes the counter to 2048 to expose saturation and confirms that no page 1 read is ever issued.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    ST_REQ  = 2'd0,
    ST_EVAL = 2'd1,
    ST_DONE = 2'd2
  } scan_st_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbs_addr_gen.sv
module bbs_addr_gen #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             page_adv_i,
  input  logic             blk_adv_i,
  output logic [BLK_W-1:0] blk_o,
  output logic             page1_o,
  output logic             last_blk_o,
  output logic [ROW_W-1:0] row_o
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  logic [BLK_W-1:0] blk_q;
  logic             page1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      page1_q <= 1'b0;
    end else if (blk_adv_i) begin
      blk_q   <= blk_q + BLK_W'(1);
      page1_q <= 1'b0;
    end else if (page_adv_i) begin
      page1_q <= 1'b1;
    end
  end

  assign blk_o      = blk_q;
  assign page1_o    = page1_q;
  assign last_blk_o = (blk_q == LAST_BLK);
  assign row_o      = {blk_q, PG_W'(page1_q)};
endmodule

// File: rtl/bbs_mark_eval.sv
module bbs_mark_eval (
  input  logic [7:0] byte_i,
  input  logic       err_i,
  output logic       mark_o
);
  import bbs_pkg::*;
  // any non-erased byte or a failed read counts as a mark
  assign mark_o = err_i | (byte_i != ERASED_BYTE);
endmodule

// File: rtl/bbs_bad_table.sv
module bbs_bad_table #(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [BLK_W-1:0] wr_idx_i,
  input  logic [BLK_W-1:0] rd_idx_i,
  output logic             rd_bad_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [NUM_BLOCKS-1:0] bits_q;
  logic [CNT_W-1:0]      cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (wr_en_i) begin
      bits_q[wr_idx_i] <= 1'b1;
      cnt_q            <= cnt_q + CNT_W'(1);
    end
  end

  assign rd_bad_o = bits_q[rd_idx_i];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int COL_W           = 12,
  parameter int SPARE_COL       = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS),
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK),
  localparam int ROW_W = BLK_W + PG_W,
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             req_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  input  logic             ack_i,
  input  logic [7:0]       rdata_i,
  input  logic             err_i,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] bad_cnt_o,
  input  logic [BLK_W-1:0] tbl_idx_i,
  output logic             tbl_bad_o
);
  import bbs_pkg::*;

  scan_st_e         st_q, st_d;
  logic [7:0]       byte_q;
  logic             rerr_q;
  logic             err_q;
  logic             mark;
  logic             page1;
  logic             last_blk;
  logic             in_eval;
  logic             page_adv;
  logic             blk_adv;
  logic [BLK_W-1:0] blk;

  bbs_addr_gen #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .page_adv_i(page_adv),
    .blk_adv_i (blk_adv),
    .blk_o     (blk),
    .page1_o   (page1),
    .last_blk_o(last_blk),
    .row_o     (row_o)
  );

  bbs_mark_eval u_eval (
    .byte_i(byte_q),
    .err_i (rerr_q),
    .mark_o(mark)
  );

  bbs_bad_table #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (in_eval & mark),
    .wr_idx_i(blk),
    .rd_idx_i(tbl_idx_i),
    .rd_bad_o(tbl_bad_o),
    .cnt_o   (bad_cnt_o)
  );

  assign in_eval  = (st_q == ST_EVAL);
  assign page_adv = in_eval & ~mark & ~page1;
  assign blk_adv  = in_eval & (mark | page1) & ~last_blk;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_REQ:  if (ack_i) st_d = ST_EVAL;
      ST_EVAL: st_d = ((mark | page1) & last_blk) ? ST_DONE : ST_REQ;
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_REQ;
      byte_q <= ERASED_BYTE;
      rerr_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_REQ && ack_i) begin
        byte_q <= rdata_i;
        rerr_q <= err_i;
      end
      if (in_eval && rerr_q) err_q <= 1'b1;
    end
  end

  assign req_o  = (st_q == ST_REQ);
  assign col_o  = COL_W'(SPARE_COL);
  assign done_o = (st_q == ST_DONE);
  assign err_o  = err_q;
endmodule

// File: rtl/bbs_scan_checker.sv
module bbs_scan_checker #(
  parameter int ROW_W     = 17,
  parameter int COL_W     = 12,
  parameter int CNT_W     = 12,
  parameter int SPARE_COL = 2048
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_o,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic             ack_i,
  input logic             err_i,
  input logic             done_o,
  input logic             err_o,
  input logic [CNT_W-1:0] bad_cnt_o
);
  assert_col_fixed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> col_o == COL_W'(SPARE_COL));

  assert_page_field_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> row_o[5:1] == 5'd0);

  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> (req_o && $stable(row_o)));

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ($stable(bad_cnt_o) || bad_cnt_o == $past(bad_cnt_o) + CNT_W'(1)));

  assert_err_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && ack_i && err_i) |=> ##1 err_o);

  assert_err_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  assert_done_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  assert_done_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
endmodule

bind bad_block_scan bbs_scan_checker #(
  .ROW_W    (ROW_W),
  .COL_W    (COL_W),
  .CNT_W    (CNT_W),
  .SPARE_COL(SPARE_COL)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_o    (req_o),
  .row_o    (row_o),
  .col_o    (col_o),
  .ack_i    (ack_i),
  .err_i    (err_i),
  .done_o   (done_o),
  .err_o    (err_o),
  .bad_cnt_o(bad_cnt_o)
);

// File: tb/bad_block_scan_bench.sv
module bad_block_scan_bench;
  localparam int NB    = 2048;
  localparam int BLK_W = 11;
  localparam int ROW_W = 17;
  localparam int COL_W = 12;
  localparam int CNT_W = 12;
  localparam int LAT   = 2;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             req_o;
  logic [ROW_W-1:0] row_o;
  logic [COL_W-1:0] col_o;
  logic             ack_i = 1'b0;
  logic [7:0]       rdata_i = 8'hFF;
  logic             err_i = 1'b0;
  logic             done_o;
  logic             err_o;
  logic [CNT_W-1:0] bad_cnt_o;
  logic [BLK_W-1:0] tbl_idx_i = '0;
  logic             tbl_bad_o;

  int checks = 0;
  int fails  = 0;
  int mode   = 0;
  int exp_blk, exp_pg, seq_err, col_err, n_req, n_p1, late_req;
  bit resp_on = 1'b0;

  always #10 clk_i = ~clk_i;

  bad_block_scan u_bad_block_scan (.*);

  function automatic logic [7:0] spare_byte(int md, int b, int p);
    if (md == 2) return (p == 0) ? 8'h00 : 8'hFF;
    if (md == 1) begin
      if (p == 0 && b % 7 == 3)  return 8'h00;
      if (p == 0 && b % 13 == 4) return 8'h7F;
      if (p == 1 && b % 11 == 5) return 8'hFE;
    end
    return 8'hFF;
  endfunction

  function automatic bit rd_err(int md, int b, int p);
    return (md == 1 && p == 0 && b % 97 == 13);
  endfunction

  function automatic bit exp_bad(int md, int b);
    return rd_err(md, b, 0) || spare_byte(md, b, 0) != 8'hFF
        || spare_byte(md, b, 1) != 8'hFF;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sequencer model: checks each request against the expected walk
  initial begin
    forever begin
      @(negedge clk_i);
      ack_i = 1'b0;
      if (resp_on && rst_ni && done_o && req_o) late_req++;
      if (resp_on && rst_ni && req_o) begin
        logic [7:0] d;
        bit e;
        n_req++;
        if (row_o != ROW_W'((exp_blk << 6) | exp_pg)) seq_err++;
        if (col_o != COL_W'(2048)) col_err++;
        if (exp_pg == 1) n_p1++;
        d = spare_byte(mode, exp_blk, exp_pg);
        e = rd_err(mode, exp_blk, exp_pg);
        repeat (LAT) @(negedge clk_i);
        ack_i = 1'b1; rdata_i = d; err_i = e;
        if (exp_pg == 0 && !e && d == 8'hFF) exp_pg = 1;
        else begin exp_pg = 0; exp_blk++; end
      end
    end
  end

  task automatic start_scan(int md);
    resp_on = 1'b0;
    mode = md;
    exp_blk = 0; exp_pg = 0; seq_err = 0; col_err = 0;
    n_req = 0; n_p1 = 0; late_req = 0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(req_o && row_o == '0 && col_o == COL_W'(2048), "R1 first request", int'(row_o), 0);
    chk(!done_o && !err_o && bad_cnt_o == '0, "R1 reset flags", int'(bad_cnt_o), 0);
    tbl_idx_i = 11'd5;
    #1 chk(tbl_bad_o == 1'b0, "R1 table cleared", tbl_bad_o, 0);
    resp_on = 1'b1;
  endtask

  task automatic finish_scan(int md, string tag);
    int exp_cnt = 0, exp_p1 = 0, exp_req, tbl_err = 0;
    while (!done_o) @(negedge clk_i);
    repeat (20) @(negedge clk_i);
    for (int b = 0; b < NB; b++) begin
      if (exp_bad(md, b)) exp_cnt++;
      if (!rd_err(md, b, 0) && spare_byte(md, b, 0) == 8'hFF) exp_p1++;
    end
    exp_req = NB + exp_p1;
    chk(seq_err == 0, {tag, " R2 R7 row order"}, seq_err, 0);
    chk(col_err == 0, {tag, " R2 column 2048"}, col_err, 0);
    chk(n_p1 == exp_p1, {tag, " R3 page1 reads"}, n_p1, exp_p1);
    chk(n_req == exp_req, {tag, " R7 total requests"}, n_req, exp_req);
    chk(late_req == 0 && !req_o, {tag, " R7 quiet after done"}, late_req, 0);
    chk(int'(bad_cnt_o) == exp_cnt, {tag, " R5 bad count"}, int'(bad_cnt_o), exp_cnt);
    for (int b = 0; b < NB; b++) begin
      tbl_idx_i = BLK_W'(b);
      #1 if (tbl_bad_o != exp_bad(md, b)) tbl_err++;
    end
    chk(tbl_err == 0, {tag, " R4 table contents"}, tbl_err, 0);
  endtask

  task automatic test_all_good();
    start_scan(0);
    finish_scan(0, "good");
    chk(err_o == 1'b0, "good R6 no error", err_o, 0);
  endtask

  task automatic test_mixed();
    start_scan(1);
    while (exp_blk < 200) @(negedge clk_i);
    tbl_idx_i = 11'd3;
    #1 chk(tbl_bad_o == 1'b1, "mixed R8 scanned bad visible", tbl_bad_o, 1);
    tbl_idx_i = 11'd2005;
    #1 chk(tbl_bad_o == 1'b0, "mixed R8 unscanned reads 0", tbl_bad_o, 0);
    finish_scan(1, "mixed");
    tbl_idx_i = 11'd5;
    #1 chk(tbl_bad_o == 1'b1, "mixed R4 page1 FEh mark", tbl_bad_o, 1);
    tbl_idx_i = 11'd4;
    #1 chk(tbl_bad_o == 1'b1, "mixed R4 page0 7Fh mark", tbl_bad_o, 1);
    tbl_idx_i = 11'd13;
    #1 chk(tbl_bad_o == 1'b1, "mixed R6 error marks block", tbl_bad_o, 1);
    tbl_idx_i = 11'd0;
    #1 chk(tbl_bad_o == 1'b0, "mixed R4 clean block good", tbl_bad_o, 0);
    chk(err_o == 1'b1, "mixed R6 sticky error", err_o, 1);
    chk(bad_cnt_o > 40, "mixed R5 count above 40", int'(bad_cnt_o), 41);
  endtask

  task automatic test_all_bad();
    start_scan(2);
    finish_scan(2, "allbad");
    chk(int'(bad_cnt_o) == NB, "allbad R5 no saturation", int'(bad_cnt_o), NB);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    fails++;
    $display("FAIL R7 watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    test_all_good();
    test_mixed();
    test_all_bad();
    $display("  test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule